// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block classifies every physical access below the 1 MB line, and above it, into one of three targets: system RAM with full access, system RAM that only serves reads, or the PCI bus. The upper BIOS area and twelve 16 KB expansion pieces each have a programmable 2-bit attribute. A second control byte, together with a system-management mode input, decides whether the 128 KB window at 0xA0000 shows the RAM behind it or forwards to PCI. All other addresses go to RAM when they are below a top-of-memory input, and to PCI otherwise.

The attributes are loaded through a 32-bit configuration write port. The port takes a dword address and per-byte lane enables, so one write can update several attribute bytes at once. Each access presented on the access port gives, one cycle later, a target code and a write-block flag. The flag marks a write aimed at a read-only segment, and the memory controller must drop that write.

Top module: `legwin_decoder`

## Requirements
- R1: An access sampled with `accValid` high on a rising edge produces `rspValid` high after that edge, with its result. A cycle with `accValid` low produces `rspValid` low one edge later.
- R2: Attribute code 3 gives target RAM (code 0 on `rspTarget`). Code 1 gives read-only RAM (code 1). Codes 0 and 2 give PCI (code 2).
- R3: Addresses 0xF0000 to 0xFFFFF use the attribute in bits [5:4] of configuration byte 0x59.
- R4: The 16 KB piece k (k = 0..11) at 0xC0000 + k*0x4000 uses configuration byte 0x5A + k/2. The field is bits [1:0] for even k and bits [5:4] for odd k.
- R5: Configuration byte offset A is lane A[1:0] of the dword at `cfgAddr` = A with bits [1:0] cleared. A lane is written only when its `cfgByteEn` bit is set. Writes to other offsets have no effect. A write changes the decode only for accesses sampled on later edges.
- R6: The window 0xA0000 to 0xBFFFF gives RAM when (`smmMode` high and bit 3 of byte 0x72 set) or bit 6 of byte 0x72 set. Otherwise it gives PCI.
- R7: `smmMode` is applied on the same edge at which the access is sampled.
- R8: An address outside the segments and the window gives RAM when it is strictly below `topOfMem`, and PCI otherwise.
- R9: `rspWrBlock` is high exactly when the access was a write and its target is read-only RAM.
- R10: During and after reset, `rspValid` and `rspWrBlock` are low and `rspTarget` is PCI. All segment attributes are 0. Byte 0x72 holds 0x02, so the window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address, dword aligned |
| cfgByteEn | input | 4 | Byte lane enables |
| cfgWrData | input | 32 | Configuration write data |
| smmMode | input | 1 | System-management mode active |
| topOfMem | input | ADDR_W | First address above installed RAM |
| accValid | input | 1 | Access present |
| accAddr | input | ADDR_W | Access physical address |
| accWrite | input | 1 | Access is a write |
| rspValid | output | 1 | Result valid |
| rspTarget | output | 2 | 0 RAM, 1 read-only RAM, 2 PCI |
| rspWrBlock | output | 1 | Write must be dropped |

## Verification
The bench builds the decoder with `ADDR_W` = 24. This gives a 16 MB space, so random addresses and random `topOfMem` values regularly fall on both sides of the 1 MB line, and the pass-through compare is tested above as well as below the legacy area. Random configuration writes aim mostly at the three dwords that hold the attribute and window bytes, with random lane enables. This exercises partial updates and writes that land in the same cycle as an access.

// File: rtl/legwin_pkg.sv
package legwin_pkg;

  localparam int NUM_PIECES  = 12;
  localparam int NUM_SEG     = NUM_PIECES + 1;
  localparam int PIECE_BYTES = 16384;
  localparam int PIECE_SHIFT = $clog2(PIECE_BYTES);
  localparam int PIECE_IDX_W = $clog2(NUM_PIECES);

  localparam logic [31:0] WIN_BASE    = 32'h000A_0000;
  localparam logic [31:0] LOW_BASE    = 32'h000C_0000;
  localparam logic [31:0] TOP_BASE    = 32'h000F_0000;
  localparam logic [31:0] LEGACY_END  = 32'h0010_0000;

  localparam logic [7:0] OFF_TOP_ATTR = 8'h59;
  localparam logic [7:0] OFF_LOW_ATTR = 8'h5A;
  localparam logic [7:0] OFF_SMM_CTRL = 8'h72;
  localparam int         SMM_GATE_BIT  = 3;
  localparam int         SMM_FORCE_BIT = 6;

  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_ROM = 2'd1,
    TGT_PCI = 2'd2
  } tgt_e;

  typedef struct packed {
    logic [NUM_SEG-1:0][1:0] segAttr;
    logic                    winOpen;
  } cfgView_t;

  function automatic tgt_e attrToTgt(input logic [1:0] attr);
    case (attr)
      2'd3:    return TGT_RAM;
      2'd1:    return TGT_ROM;
      default: return TGT_PCI;
    endcase
  endfunction

endpackage

// File: rtl/legwin_cfg_ctrl.sv
module legwin_cfg_ctrl
  import legwin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgAddr,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  input  logic        smmMode,
  output cfgView_t    cfgView
);

  logic [NUM_SEG-1:0][1:0] segAttr;

  // One 2-bit field per segment; each knows its byte offset and bit slot.
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam logic [7:0] BYTE_OFF = (s == 0) ? OFF_TOP_ATTR
                                    : 8'(int'(OFF_LOW_ATTR) + (s - 1) / 2);
    localparam int BIT_LO = (s == 0) ? 4 : (((s - 1) % 2) == 0 ? 0 : 4);
    localparam int LANE   = int'(BYTE_OFF[1:0]);

    logic       laneHit;
    logic [1:0] fieldQ;

    assign laneHit = cfgWrEn && (cfgAddr[7:2] == BYTE_OFF[7:2]) && cfgByteEn[LANE];

    always_ff @(posedge clk) begin
      if (!rstN)        fieldQ <= 2'd0;
      else if (laneHit) fieldQ <= cfgWrData[LANE*8 + BIT_LO +: 2];
    end

    assign segAttr[s] = fieldQ;
  end

  localparam int SMM_LANE = int'(OFF_SMM_CTRL[1:0]);

  logic smmHit, smmGateQ, smmForceQ;

  assign smmHit = cfgWrEn && (cfgAddr[7:2] == OFF_SMM_CTRL[7:2]) && cfgByteEn[SMM_LANE];

  // Reset byte value 0x02 leaves both window bits clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      smmGateQ  <= 1'b0;
      smmForceQ <= 1'b0;
    end else if (smmHit) begin
      smmGateQ  <= cfgWrData[SMM_LANE*8 + SMM_GATE_BIT];
      smmForceQ <= cfgWrData[SMM_LANE*8 + SMM_FORCE_BIT];
    end
  end

  assign cfgView.segAttr = segAttr;
  assign cfgView.winOpen = (smmMode && smmGateQ) || smmForceQ;

  // R5: attributes move only after a configuration write
  a_r5_attr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(segAttr));

  // R6: force bit alone opens the window
  a_r6_force_open: assert property (@(posedge clk) disable iff (!rstN)
    (smmHit && cfgWrData[SMM_LANE*8 + SMM_FORCE_BIT]) |=> cfgView.winOpen);

endmodule

// File: rtl/legwin_addr_dp.sv
module legwin_addr_dp
  import legwin_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgView_t          cfgView,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] topOfMem,
  output logic              rspValid,
  output tgt_e              rspTarget,
  output logic              rspWrBlock
);

  localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] A_LOW = ADDR_W'(LOW_BASE);
  localparam logic [ADDR_W-1:0] A_TOP = ADDR_W'(TOP_BASE);
  localparam logic [ADDR_W-1:0] A_END = ADDR_W'(LEGACY_END);

  logic                   inTop, inLow, inWin;
  logic [ADDR_W-1:0]      lowOffs;
  logic [PIECE_IDX_W-1:0] pieceNum;
  logic [1:0]             pieceAttr;
  tgt_e                   tgtNext;

  assign inTop    = (accAddr >= A_TOP) && (accAddr < A_END);
  assign inLow    = (accAddr >= A_LOW) && (accAddr < A_TOP);
  assign inWin    = (accAddr >= A_WIN) && (accAddr < A_LOW);
  assign lowOffs  = accAddr - A_LOW;
  assign pieceNum = lowOffs[PIECE_SHIFT +: PIECE_IDX_W];

  always_comb begin
    pieceAttr = 2'd0;
    for (int k = 0; k < NUM_PIECES; k++) begin
      if (pieceNum == PIECE_IDX_W'(k)) pieceAttr = cfgView.segAttr[k+1];
    end
  end

  always_comb begin
    if (inTop)      tgtNext = attrToTgt(cfgView.segAttr[0]);
    else if (inLow) tgtNext = attrToTgt(pieceAttr);
    else if (inWin) tgtNext = cfgView.winOpen ? TGT_RAM : TGT_PCI;
    else            tgtNext = (accAddr < topOfMem) ? TGT_RAM : TGT_PCI;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspTarget  <= TGT_PCI;
      rspWrBlock <= 1'b0;
    end else begin
      rspValid <= accValid;
      if (accValid) begin
        rspTarget  <= tgtNext;
        rspWrBlock <= accWrite && (tgtNext == TGT_ROM);
      end else begin
        rspWrBlock <= 1'b0;
      end
    end
  end

  // R1: one-cycle result
  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> rspValid);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !rspValid);

  // R3: read-only top segment yields read-only target
  a_r3_top_rom: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && inTop && cfgView.segAttr[0] == 2'd1) |=> rspTarget == TGT_ROM);

  // R6: closed window forwards to PCI
  a_r6_closed: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && inWin && !cfgView.winOpen) |=> rspTarget == TGT_PCI);

  // R9: block flag only on a read-only result
  a_r9_block: assert property (@(posedge clk) disable iff (!rstN)
    rspWrBlock |-> (rspValid && rspTarget == TGT_ROM));

endmodule

// File: rtl/legwin_decoder.sv
module legwin_decoder
  import legwin_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWrData,
  input  logic              smmMode,
  input  logic [ADDR_W-1:0] topOfMem,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  output logic              rspValid,
  output logic [1:0]        rspTarget,
  output logic              rspWrBlock
);

  cfgView_t cfgView;
  tgt_e     tgtQ;

  legwin_cfg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgByteEn (cfgByteEn),
    .cfgWrData (cfgWrData),
    .smmMode   (smmMode),
    .cfgView   (cfgView)
  );

  legwin_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgView    (cfgView),
    .accValid   (accValid),
    .accAddr    (accAddr),
    .accWrite   (accWrite),
    .topOfMem   (topOfMem),
    .rspValid   (rspValid),
    .rspTarget  (tgtQ),
    .rspWrBlock (rspWrBlock)
  );

  assign rspTarget = tgtQ;

endmodule

// File: tb/legwin_decoder_tb_top.sv
module legwin_decoder_tb_top;

  localparam int AW = 24;
  localparam logic [1:0] E_RAM = 2'd0, E_ROM = 2'd1, E_PCI = 2'd2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgWrEn;
  logic [7:0]    cfgAddr;
  logic [3:0]    cfgByteEn;
  logic [31:0]   cfgWrData;
  logic          smmMode;
  logic [AW-1:0] topOfMem;
  logic          accValid;
  logic [AW-1:0] accAddr;
  logic          accWrite;
  logic          rspValid;
  logic [1:0]    rspTarget;
  logic          rspWrBlock;

  int checks = 0;
  int errors = 0;

  logic [1:0] segM [13];
  logic       gateM, forceM;

  always #4 clk = ~clk;

  legwin_decoder #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .smmMode(smmMode),
    .topOfMem(topOfMem), .accValid(accValid), .accAddr(accAddr),
    .accWrite(accWrite), .rspValid(rspValid), .rspTarget(rspTarget),
    .rspWrBlock(rspWrBlock)
  );

  function automatic logic [1:0] mapAttr(input logic [1:0] a);
    if (a == 2'd3) return E_RAM;
    if (a == 2'd1) return E_ROM;
    return E_PCI;
  endfunction

  function automatic logic [1:0] expTgt(input logic [AW-1:0] a, input logic md,
                                        input logic [AW-1:0] top);
    int k;
    if (a >= 24'hF0000 && a < 24'h100000) return mapAttr(segM[0]);
    if (a >= 24'hC0000 && a < 24'hF0000) begin
      k = int'((a - 24'hC0000) >> 14);
      return mapAttr(segM[k+1]);
    end
    if (a >= 24'hA0000 && a < 24'hC0000) return ((md && gateM) || forceM) ? E_RAM : E_PCI;
    return (a < top) ? E_RAM : E_PCI;
  endfunction

  task automatic modelWrite(input logic [7:0] wa, input logic [3:0] be, input logic [31:0] wd);
    for (int b = 0; b < 4; b++) begin
      logic [7:0] ba;
      logic [7:0] d;
      ba = {wa[7:2], 2'(b)};
      d  = wd[8*b +: 8];
      if (be[b]) begin
        if (ba == 8'h59) segM[0] = d[5:4];
        if (ba >= 8'h5A && ba <= 8'h5F) begin
          segM[2*(ba-8'h5A)+1] = d[1:0];
          segM[2*(ba-8'h5A)+2] = d[5:4];
        end
        if (ba == 8'h72) begin
          gateM  = d[3];
          forceM = d[6];
        end
      end
    end
  endtask

  task automatic check(input logic ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual {valid,target,block}=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic step(input logic we, input logic [7:0] wa, input logic [3:0] be,
                      input logic [31:0] wd, input logic av, input logic [AW-1:0] aa,
                      input logic aw, input logic md, input logic [AW-1:0] top,
                      input string req);
    logic [1:0] et;
    logic       eb;
    logic [3:0] ev, ac;
    cfgWrEn = we; cfgAddr = wa; cfgByteEn = be; cfgWrData = wd;
    accValid = av; accAddr = aa; accWrite = aw; smmMode = md; topOfMem = top;
    et = expTgt(aa, md, top);
    eb = aw && (et == E_ROM);
    if (we) modelWrite(wa, be, wd);
    @(negedge clk);
    ac = {rspValid, rspTarget, rspWrBlock};
    if (av) begin
      ev = {1'b1, et, eb};
      check(ac == ev, req, ac, ev);
    end else begin
      ev = {1'b0, ac[2:1], 1'b0};
      check(!rspValid && !rspWrBlock, req, ac, ev);
    end
  endtask

  task automatic acc(input logic [AW-1:0] a, input logic w, input logic md,
                     input logic [AW-1:0] top, input string req);
    step(1'b0, 8'h00, 4'h0, 32'h0, 1'b1, a, w, md, top, req);
  endtask

  task automatic cfg(input logic [7:0] wa, input logic [3:0] be, input logic [31:0] wd, input string req);
    step(1'b1, wa, be, wd, 1'b0, '0, 1'b0, 1'b0, 24'h400000, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < 13; i++) segM[i] = 2'd0;
    gateM = 1'b0; forceM = 1'b0;
    rstN = 1'b0; cfgWrEn = 0; cfgAddr = 0; cfgByteEn = 0; cfgWrData = 0;
    smmMode = 0; topOfMem = 0; accValid = 0; accAddr = 0; accWrite = 0;
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    check(!rspValid && rspTarget == E_PCI && !rspWrBlock, "R10",
          {rspValid, rspTarget, rspWrBlock}, {1'b0, E_PCI, 1'b0});
    rstN = 1'b1;

    // R10: reset attributes forward to PCI, window closed
    acc(24'hF8000, 1'b0, 1'b1, 24'h800000, "R10 top segment");
    acc(24'hC4000, 1'b1, 1'b1, 24'h800000, "R10 low piece");
    acc(24'hA0000, 1'b0, 1'b1, 24'h800000, "R10 window");
    // R1: idle cycle
    step(1'b0, 8'h0, 4'h0, 32'h0, 1'b0, '0, 1'b0, 1'b0, '0, "R1 idle");

    // R3 and R2: top segment codes
    cfg(8'h58, 4'b0010, 32'h0000_3000, "R3 cfg");
    acc(24'hFFFFF, 1'b1, 1'b0, 24'h0, "R3 RAM write");
    cfg(8'h58, 4'b0010, 32'h0000_1000, "R2 cfg");
    acc(24'hF0000, 1'b1, 1'b0, 24'h0, "R9 write blocked");
    acc(24'hF0000, 1'b0, 1'b0, 24'h0, "R2 read-only read");
    cfg(8'h58, 4'b0010, 32'h0000_2000, "R2 cfg");
    acc(24'hF1234, 1'b1, 1'b0, 24'h0, "R2 code2 PCI");
    // R5: disabled lane ignored
    cfg(8'h58, 4'b1101, 32'h3333_3333, "R5 cfg");
    acc(24'hF1234, 1'b0, 1'b0, 24'h0, "R5 masked lane");
    // R5: write and access in same cycle use the old value
    step(1'b1, 8'h58, 4'b0010, 32'h0000_3000, 1'b1, 24'hF0010, 1'b1, 1'b0, 24'h0, "R5 same cycle");
    acc(24'hF0010, 1'b1, 1'b0, 24'h0, "R5 next cycle");

    // R4: pieces, even and odd slots
    cfg(8'h5C, 4'b1111, 32'h1331_3113, "R4 cfg");
    for (int k = 0; k < 12; k++)
      acc(24'hC0000 + 24'(k) * 24'h4000 + 24'h3FFF, 1'b1, 1'b0, 24'h0, "R4 piece");
    cfg(8'h58, 4'b1100, 32'h3100_0000, "R4 cfg low");
    acc(24'hC0000, 1'b1, 1'b0, 24'h0, "R4 piece0");
    acc(24'hC4000, 1'b1, 1'b0, 24'h0, "R4 piece1");
    // R5: unrelated offset ignored
    cfg(8'h60, 4'b1111, 32'hFFFF_FFFF, "R5 other offset");
    acc(24'hC0000, 1'b0, 1'b0, 24'h0, "R5 other offset");

    // R6 and R7: window
    cfg(8'h70, 4'b0100, 32'h0008_0000, "R6 cfg gate");
    acc(24'hA0000, 1'b0, 1'b0, 24'h0, "R6 gate no mode");
    acc(24'hBFFFF, 1'b0, 1'b1, 24'h0, "R7 mode high");
    acc(24'hB0000, 1'b1, 1'b0, 24'h0, "R7 mode low");
    cfg(8'h70, 4'b0100, 32'h0040_0000, "R6 cfg force");
    acc(24'hA8000, 1'b0, 1'b0, 24'h0, "R6 force");

    // R8: pass-through around top of memory
    acc(24'h07FFFF, 1'b1, 1'b0, 24'h080000, "R8 below top");
    acc(24'h080000, 1'b1, 1'b0, 24'h080000, "R8 at top");
    acc(24'h200000, 1'b0, 1'b0, 24'h800000, "R8 high RAM");
    acc(24'h900000, 1'b0, 1'b0, 24'h800000, "R8 high PCI");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic          we;
      logic [7:0]    wa;
      logic [AW-1:0] a;
      int            sel;
      we  = ($urandom % 4) == 0;
      sel = $urandom % 4;
      wa  = (sel == 0) ? 8'h58 : (sel == 1) ? 8'h5C : (sel == 2) ? 8'h70 : 8'($urandom) & 8'hFC;
      sel = $urandom % 4;
      if (sel == 0)      a = 24'hA0000 + 24'($urandom % 32'h60000);
      else if (sel == 1) a = 24'($urandom % 32'h100000);
      else if (sel == 2) a = 24'($urandom);
      else               a = 24'hF0000 + 24'($urandom % 32'h10000);
      step(we, wa, 4'($urandom), $urandom, ($urandom % 5) != 0, a, 1'($urandom),
           1'($urandom), 24'($urandom), "R1 R2 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule